// File: doc/BRIEF.md
# Gated Rising-Edge Interrupt Controller

This block produces the interrupt for a digital I/O card. It watches two sense lines, which are bit 3 of port C in each of the card's two port groups. A rising edge on either line raises one shared interrupt request. The request can only be switched on, switched off and acknowledged through bus accesses at fixed offsets inside the card's 16-byte window. What matters is the kind of access, read or write, and its address. The write data is never looked at. Software finds out which line fired and does any masking per line.

Each sense input passes through a two-flop synchronizer and then a rising-edge detector. Each detected edge is a one-cycle event. An access decoder turns every bus strobe into at most one of three events: enable, disable or clear. A four-state controller tracks two things, whether the interrupt is enabled and whether a pending edge is held.

- `ST_OFF_IDLE`: disabled, nothing pending. This is the state after reset.
- `ST_OFF_HELD`: disabled, with a pending edge kept from before the disable.
- `ST_ARMED`: enabled, nothing pending.
- `ST_FIRING`: enabled and pending. The request output is high only in this state.

Transitions:
- Enable moves OFF_IDLE to ARMED and OFF_HELD to FIRING.
- Disable moves ARMED to OFF_IDLE and FIRING to OFF_HELD.
- An edge moves ARMED to FIRING. If a disable arrives in the same cycle, it moves ARMED to OFF_HELD instead.
- Clear moves FIRING to ARMED and OFF_HELD to OFF_IDLE, unless an edge arrives in the same cycle while the interrupt is enabled.

Every event is judged against the enable state at the start of its cycle.

Top module: `edge_irq_gate`

## Requirements
- R1: After reset the interrupt is disabled, `irq_req` is 0 and nothing is pending. A later enable with no edge leaves `irq_req` at 0.
- R2: A write strobe at offset 0xB enables the interrupt, whatever the value on `bus_wdata`.
- R3: A read strobe at offset 0xB disables the interrupt. `irq_req` is 0 from the next cycle on. A pending edge is kept and shows again on `irq_req` after a later enable.
- R4: A write strobe at offset 0xF clears the pending edge, whatever the data. `irq_req` is 0 from the next cycle on. A clear also works while the interrupt is disabled. A read at 0xF has no effect.
- R5: While the interrupt is enabled, a rising edge on either `sense_in[0]` or `sense_in[1]` sets the pending flag. `irq_req` then stays 1 until a clear or a disable.
- R6: Only a 0-to-1 change counts as an edge. A falling edge does not set the pending flag. Neither does a line that is held at 1 through a clear.
- R7: An edge is ignored while the interrupt is disabled. This includes an edge that arrives in the same cycle as the enable write.
- R8: When an edge is detected in the same cycle as a clear write, and the interrupt is enabled, the edge wins and `irq_req` stays 1.
- R9: Reads and writes at any offset other than 0xB and 0xF have no effect. If both strobes are high at offset 0xB in the same cycle, the disable wins.
- R10: The sense inputs are synchronized. For a sense line that rises between two clock edges while the interrupt is enabled, `irq_req` goes to 1 at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 4 | Offset inside the 16-byte window |
| bus_wdata | input | 8 | Write data, ignored |
| sense_in | input | 2 | Asynchronous sense lines: group 0 and group 1, port C bit 3 |
| irq_req | output | 1 | Shared interrupt request |

## Verification
The bench goes after the corner cases where cycles coincide, because that is where a careless controller fails:
- A clear write in the same cycle as a detected edge. A design that lets the clear win drops an edge.
- An edge in the same cycle as the enable write. A design that looks at the next enable state raises a request that software never asked for.
- Both strobes at 0xB in one cycle. Letting the write win leaves the interrupt enabled.
- A disable while an edge is pending. A design that clears the pending flag on disable loses the edge, so no request appears after re-enabling.

It also measures the exact synchronizer latency, and holds a line high through a clear to catch a design that detects levels instead of edges. It then runs a seeded random mix of accesses at all offsets, with random data and line pulses, against a model of the enable and pending flags.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    // Controller state: enable flag crossed with pending flag
    typedef enum logic [1:0] {
        ST_OFF_IDLE = 2'd0,
        ST_OFF_HELD = 2'd1,
        ST_ARMED    = 2'd2,
        ST_FIRING   = 2'd3
    } irq_state_t;

    // Control events decoded from one bus cycle
    typedef struct packed {
        logic en_req;
        logic dis_req;
        logic clr_req;
    } ctl_evt_t;

endpackage

// File: rtl/eig_line_sense.sv
module eig_line_sense #(
    parameter int NUM_LINES   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] sense_async,
    output logic [NUM_LINES-1:0] rise,
    output logic                 edge_any
);

    localparam int TOP = SYNC_STAGES - 1;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
                last  <= 1'b0;
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], sense_async[i]};
                last  <= chain[TOP];
            end
        end

        // One-cycle pulse on a synchronized 0 -> 1 change
        assign rise[i] = chain[TOP] & ~last;
    end

    assign edge_any = |rise;

endmodule

// File: rtl/eig_access_decode.sv
module eig_access_decode
    import edge_irq_pkg::*;
#(
    parameter int             ADDR_W     = 4,
    parameter int             DATA_W     = 8,
    parameter logic [ADDR_W-1:0] ENABLE_OFS = 4'hB,
    parameter logic [ADDR_W-1:0] CLEAR_OFS  = 4'hF
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output ctl_evt_t          evt
);

    logic hit_enable;
    logic hit_clear;
    logic unused_wdata;

    assign hit_enable = (bus_addr == ENABLE_OFS);
    assign hit_clear  = (bus_addr == CLEAR_OFS);

    // The data value carries no meaning for any control action
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        evt         = '0;
        evt.dis_req = bus_rd & hit_enable;
        evt.en_req  = bus_wr & hit_enable & ~bus_rd;  // a read at the same offset wins
        evt.clr_req = bus_wr & hit_clear;
    end

endmodule

// File: rtl/eig_ctrl_fsm.sv
module eig_ctrl_fsm
    import edge_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ctl_evt_t evt,
    input  logic     edge_any,
    output logic     irq_req
);

    irq_state_t state_q;
    irq_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: events judged against the enable state at cycle start
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF_IDLE: begin
                if (evt.en_req) begin
                    state_d = ST_ARMED;
                end
            end
            ST_OFF_HELD: begin
                if (evt.clr_req) begin
                    state_d = evt.en_req ? ST_ARMED : ST_OFF_IDLE;
                end else if (evt.en_req) begin
                    state_d = ST_FIRING;
                end
            end
            ST_ARMED: begin
                if (edge_any) begin
                    state_d = evt.dis_req ? ST_OFF_HELD : ST_FIRING;
                end else if (evt.dis_req) begin
                    state_d = ST_OFF_IDLE;
                end
            end
            ST_FIRING: begin
                if (evt.dis_req) begin
                    state_d = (evt.clr_req && !edge_any) ? ST_OFF_IDLE : ST_OFF_HELD;
                end else if (evt.clr_req && !edge_any) begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_OFF_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_req = (state_q == ST_FIRING);
    end

endmodule

// File: rtl/edge_irq_gate.sv
module edge_irq_gate
    import edge_irq_pkg::*;
#(
    parameter int             NUM_LINES   = 2,
    parameter int             SYNC_STAGES = 2,
    parameter int             ADDR_W      = 4,
    parameter int             DATA_W      = 8,
    parameter logic [ADDR_W-1:0] ENABLE_OFS  = 4'hB,
    parameter logic [ADDR_W-1:0] CLEAR_OFS   = 4'hF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [NUM_LINES-1:0] sense_in,
    output logic                 irq_req
);

    logic [NUM_LINES-1:0] rise;
    logic                 edge_any;
    ctl_evt_t             evt;
    logic                 unused_rise;

    assign unused_rise = ^rise;

    eig_line_sense #(
        .NUM_LINES  (NUM_LINES),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .sense_async(sense_in),
        .rise       (rise),
        .edge_any   (edge_any)
    );

    eig_access_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ENABLE_OFS(ENABLE_OFS),
        .CLEAR_OFS (CLEAR_OFS)
    ) u_decode (
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .evt      (evt)
    );

    eig_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .edge_any(edge_any),
        .irq_req (irq_req)
    );

endmodule

// File: rtl/edge_irq_gate_chk.sv
module edge_irq_gate_chk #(
    parameter int             ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] ENABLE_OFS = 4'hB,
    parameter logic [ADDR_W-1:0] CLEAR_OFS  = 4'hF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              edge_any,
    input logic              irq_req
);

    // R3
    read_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ENABLE_OFS) |=> !irq_req);

    // R4
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CLEAR_OFS && !edge_any) |=> !irq_req);

    // R8
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && edge_any && bus_wr && bus_addr == CLEAR_OFS) |=> irq_req);

    // R7
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(edge_any) || $past(bus_wr && bus_addr == ENABLE_OFS)));

    // R9
    other_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_any && (bus_rd || bus_wr) && bus_addr != ENABLE_OFS && bus_addr != CLEAR_OFS)
        |=> $stable(irq_req));

    // R5
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_any && !bus_rd && !bus_wr) |=> $stable(irq_req));

endmodule

bind edge_irq_gate edge_irq_gate_chk #(
    .ADDR_W    (ADDR_W),
    .ENABLE_OFS(ENABLE_OFS),
    .CLEAR_OFS (CLEAR_OFS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .edge_any(edge_any),
    .irq_req (irq_req)
);

// File: tb/edge_irq_gate_test.sv
`timescale 1ns/1ps
module edge_irq_gate_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [1:0] sense_in = 2'b00;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the two flags
    bit m_en = 1'b0;
    bit m_pend = 1'b0;

    always #2.5 clk = ~clk;

    edge_irq_gate uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .sense_in (sense_in),
        .irq_req  (irq_req)
    );

    function automatic bit exp_irq();
        return m_en && m_pend;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s irq_req actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 4'hB) m_en = 1'b1;
        if (a == 4'hF) m_pend = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        if (a == 4'hB) m_en = 1'b0;
    endtask

    task automatic pulse_line(input int ln);
        @(negedge clk);
        sense_in[ln] = 1'b1;
        idle(3);
        sense_in[ln] = 1'b0;
        if (m_en) m_pend = 1'b1;
        idle(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        idle(3);
        check("R1 during reset", irq_req, 1'b0);
        rst_n = 1'b1;
        idle(2);
        check("R1 after reset", irq_req, 1'b0);
        pulse_line(0);  // disabled: ignored
        check("R7 edge while disabled", irq_req, 1'b0);
        bus_write(4'hB, 8'h00);
        idle(3);
        check("R1 enable with nothing pending", irq_req, 1'b0);

        // R10 latency: change just after a negedge, high after third posedge
        @(negedge clk);
        sense_in[0] = 1'b1;
        @(negedge clk);
        check("R10 one edge in", irq_req, 1'b0);
        @(negedge clk);
        check("R10 two edges in", irq_req, 1'b0);
        @(negedge clk);
        check("R10 third edge", irq_req, 1'b1);
        m_pend = 1'b1;
        // R6: line still high through a clear, then falls
        bus_write(4'hF, 8'hFF);
        idle(4);
        check("R6 held level after clear", irq_req, 1'b0);
        sense_in[0] = 1'b0;
        idle(5);
        check("R6 falling edge", irq_req, 1'b0);

        // R5 line 1
        pulse_line(1);
        check("R5 line 1 edge", irq_req, 1'b1);
        bus_read(4'hF);
        idle(2);
        check("R4 read at clear offset", irq_req, 1'b1);

        // R8 edge and clear in the same cycle (pending already set)
        @(negedge clk);
        sense_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'hF; bus_wdata = 8'h5A;
        @(negedge clk);
        bus_wr = 1'b0;
        idle(2);
        check("R8 edge beats clear", irq_req, 1'b1);
        sense_in[0] = 1'b0;
        idle(4);
        bus_write(4'hF, 8'h00);
        idle(2);
        check("R4 clear", irq_req, 1'b0);
        m_pend = 1'b0;

        // R3 disable keeps pending
        pulse_line(0);
        bus_read(4'hB);
        idle(2);
        check("R3 disable with pending", irq_req, 1'b0);
        bus_write(4'hB, 8'hC3);
        idle(2);
        check("R3 pending shown after re-enable", irq_req, 1'b1);
        bus_read(4'hB);
        bus_write(4'hF, 8'h00);
        bus_write(4'hB, 8'h00);
        idle(2);
        check("R4 clear while disabled", irq_req, 1'b0);

        // R7 edge in the same cycle as the enable write
        bus_read(4'hB);
        idle(2);
        @(negedge clk);
        sense_in[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'hB; bus_wdata = 8'hFF;
        @(negedge clk);
        bus_wr = 1'b0;
        m_en = 1'b1;
        idle(3);
        check("R7 edge with enable write", irq_req, 1'b0);
        sense_in[1] = 1'b0;
        idle(4);

        // R9 both strobes at 0xB: disable wins
        pulse_line(1);
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 4'hB;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        m_en = 1'b0;
        idle(2);
        check("R9 read and write at 0xB", irq_req, 1'b0);
        bus_write(4'hB, 8'h00);
        bus_write(4'h3, 8'hFF);
        bus_read(4'h7);
        idle(2);
        check("R9 other offsets", irq_req, 1'b1);

        // Random mix; R2 data independence, R9 offsets
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [3:0] a;
            op = $urandom_range(0, 5);
            a  = 4'($urandom_range(0, 15));
            case (op)
                0: bus_write(4'hB, 8'($urandom));
                1: bus_read(4'hB);
                2: bus_write(4'hF, 8'($urandom));
                3: if (a[0]) bus_write(a, 8'($urandom)); else bus_read(a);
                default: pulse_line($urandom_range(0, 1));
            endcase
            idle(2);
            check("R2 R5 R9 random", irq_req, exp_irq());
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule